// File: doc/BRIEF.md
# RMII Receive Dibit-to-Byte Assembler

This block sits between a reduced media-independent receive port and a 10/100 MAC receive engine. Everything runs on one 50 MHz reference clock. At 100 Mb/s a new two-bit receive symbol (dibit) arrives on every clock. At 10 Mb/s the same clock is used, and each symbol is held for ten clocks, so the block takes one sample in every ten. A single input line carries both carrier sense and receive data valid. The block tells these two meanings apart from the dibit pattern seen while the line is high.

When the line rises while the dibits are still 00, the block reports carrier only. The first 01 dibit seen while the line is high opens the frame and fixes byte alignment. From that dibit on, every group of four sampled dibits forms one byte, with the least significant dibit first. Each byte is presented with a one-clock strobe, and the first byte of a frame carries a start marker. A sample with the line low closes the frame. One clock later a frame-done pulse appears, carrying the sticky receive-error flag of that frame. Preamble and start-delimiter bytes are passed through as data; the MAC that follows strips them.

Top module: `rmii_rx_assembler`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, byte_vld, sof_o, eof_o, err_o and crs_o are all 0.
- R2: With speed_100=1, every clock is a sample point. Within a frame, byte_vld strobes are exactly 4 clocks apart. Each byte holds its four dibits with the first one in bits [1:0] and the last one in bits [7:6].
- R3: With speed_100=0, one clock in every 10 is a sample point. Inputs held for 10 clocks are taken exactly once each, so strobes within a frame are exactly 40 clocks apart and the byte values match R2.
- R4: Dibits of 00 sampled with crs_dv high before any 01 produce no byte. The first 01 dibit sampled with crs_dv high becomes bits [1:0] of the first byte, so a standard preamble comes out as 0x55 bytes followed by 0xD5.
- R5: crs_o goes to 1 at the sample where crs_dv is high and returns to 0 at the sample where crs_dv is low. A carrier that never shows a 01 dibit yields no byte and no eof_o.
- R6: sof_o is 1 together with the first byte_vld of a frame and 0 on every other strobe.
- R7: A sample with crs_dv low during a frame gives exactly one eof_o pulse, one clock later. Trailing dibits that do not fill a byte are dropped, so eof_o follows the last strobe by (1 + trailing dibits) sample periods.
- R8: When rx_er is sampled high on a data sample of a frame, err_o is 1 with that frame's eof_o. The flag clears when the next frame starts. rx_er outside frames has no effect, and err_o is never 1 without eof_o.
- R9: byte_vld lasts one clock, and two strobes are never fewer than 4 sample points apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1: sample every clock (100 Mb/s); 0: sample once per 10 clocks (10 Mb/s) |
| rxd | input | 2 | Receive dibit |
| crs_dv | input | 1 | Shared carrier-sense / data-valid line |
| rx_er | input | 1 | Optional receive error, tie low when unused |
| byte_o | output | 8 | Assembled byte, valid with byte_vld |
| byte_vld | output | 1 | One-clock byte strobe |
| sof_o | output | 1 | First byte of frame marker |
| eof_o | output | 1 | Frame-done pulse |
| err_o | output | 1 | Frame had a receive error, valid with eof_o |
| crs_o | output | 1 | Carrier sense flag |

## Verification
The hardest case to reach from the ports is the 10 Mb/s frame whose end falls in the middle of a byte. Here the decimation phase, the dibit count and the end sample all interact, so the distance between the last strobe and eof_o tells whether any partial byte leaked out. The stimulus holds every dibit for exactly ten clocks without knowing the internal phase, which guarantees one sample per symbol. It then appends zero to three filler dibits at both speeds and expects eof_o a whole number of sample periods after the last strobe. Error clearing is reached by sending a frame with an error directly before a clean frame that has rx_er pulsed during its carrier and idle dibits.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [1:0] {
    LN_IDLE    = 2'd0,
    LN_CARRIER = 2'd1,
    LN_DATA    = 2'd2
  } line_state_e;

  localparam logic [1:0] ALIGN_DIBIT = 2'b01;

  // number of reference clocks between sample points
  function automatic int unsigned sample_period(input logic fast, input int unsigned decim);
    return fast ? 1 : decim;
  endfunction

  // shift a new dibit into the top of a byte, older dibits move toward bit 0
  function automatic logic [7:0] push_dibit(input logic [7:0] sr, input logic [1:0] d);
    return {d, sr[7:2]};
  endfunction

endpackage

// File: rtl/rmii_rx_sampler.sv
module rmii_rx_sampler #(
  parameter int unsigned DECIM = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  localparam int unsigned CW = (DECIM > 2) ? $clog2(DECIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

  logic [CW-1:0] phase;
  logic          wrap;

  assign wrap = (phase == LAST);
  assign tick = fast | wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (fast || wrap) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/rmii_rx_linedec.sv
module rmii_rx_linedec
  import rmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       crs_dv,
  input  logic [1:0] rxd,
  output logic       start_ev,
  output logic       data_ev,
  output logic       end_ev,
  output logic       carrier
);
  line_state_e state, state_nx;
  logic        align;
  logic        in_data;

  assign align    = (rxd == ALIGN_DIBIT);
  assign in_data  = (state == LN_DATA);
  assign start_ev = tick & crs_dv & align & ~in_data;
  assign data_ev  = tick & crs_dv & in_data;
  assign end_ev   = tick & ~crs_dv & in_data;
  assign carrier  = (state != LN_IDLE);

  always_comb begin
    state_nx = state;
    if (tick) begin
      if (!crs_dv)      state_nx = LN_IDLE;
      else if (in_data) state_nx = LN_DATA;
      else if (align)   state_nx = LN_DATA;
      else              state_nx = LN_CARRIER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LN_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer
  import rmii_rx_pkg::*;
#(
  parameter int unsigned DW     = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              data_ev,
  input  logic              end_ev,
  input  logic [DW-1:0]     dibit,
  input  logic              rx_er,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld,
  output logic              sof_o,
  output logic              eof_o,
  output logic              err_o
);
  localparam int unsigned PER = BYTE_W / DW;
  localparam int unsigned CW  = (PER > 2) ? $clog2(PER) : 1;
  localparam logic [CW-1:0] LASTC = CW'(PER - 1);

  logic [BYTE_W-1:0] sr, sr_nx;
  logic [CW-1:0]     cnt;
  logic              take, last;
  logic              first_pend;
  logic              sticky;

  assign take  = start_ev | data_ev;
  assign sr_nx = push_dibit(sr, dibit);
  assign last  = data_ev & (cnt == LASTC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr         <= '0;
      cnt        <= '0;
      first_pend <= 1'b0;
      sticky     <= 1'b0;
    end else begin
      if (take) sr <= sr_nx;
      if (start_ev) begin
        cnt        <= CW'(1);
        first_pend <= 1'b1;
        sticky     <= rx_er;
      end else if (data_ev) begin
        cnt <= last ? '0 : cnt + 1'b1;
        if (rx_er) sticky <= 1'b1;
        if (last)  first_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_o   <= '0;
      byte_vld <= 1'b0;
      sof_o    <= 1'b0;
      eof_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      byte_vld <= last;
      sof_o    <= last & first_pend;
      eof_o    <= end_ev;
      err_o    <= end_ev & sticky;
      if (last) byte_o <= sr_nx;
    end
  end
endmodule

// File: rtl/rmii_rx_assembler.sv
module rmii_rx_assembler #(
  parameter int unsigned DECIM = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100,
  input  logic [1:0] rxd,
  input  logic       crs_dv,
  input  logic       rx_er,
  output logic [7:0] byte_o,
  output logic       byte_vld,
  output logic       sof_o,
  output logic       eof_o,
  output logic       err_o,
  output logic       crs_o
);
  logic tick;
  logic start_ev, data_ev, end_ev;

  rmii_rx_sampler #(.DECIM(DECIM)) u_smp (
    .clk   (clk),
    .rst_n (rst_n),
    .fast  (speed_100),
    .tick  (tick)
  );

  rmii_rx_linedec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .crs_dv   (crs_dv),
    .rxd      (rxd),
    .start_ev (start_ev),
    .data_ev  (data_ev),
    .end_ev   (end_ev),
    .carrier  (crs_o)
  );

  rmii_rx_packer #(.DW(2), .BYTE_W(8)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .data_ev  (data_ev),
    .end_ev   (end_ev),
    .dibit    (rxd),
    .rx_er    (rx_er),
    .byte_o   (byte_o),
    .byte_vld (byte_vld),
    .sof_o    (sof_o),
    .eof_o    (eof_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/rmii_rx_chk.sv
module rmii_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic speed_100,
  input logic tick,
  input logic start_ev,
  input logic end_ev,
  input logic byte_vld,
  input logic sof_o,
  input logic eof_o,
  input logic err_o,
  input logic crs_o
);
  logic [2:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)        gap <= 3'd7;
    else if (byte_vld) gap <= {2'b00, tick};
    else if (tick && gap != 3'd7) gap <= gap + 3'd1;
  end

  // R9
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R9
  byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> gap >= 3'd4);

  // R6
  sof_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> byte_vld);

  // R7
  eof_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |=> (eof_o && !crs_o));

  // R8
  err_only_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> eof_o);

  // R3
  slow_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !speed_100) |=> (!tick || speed_100));

  // R5
  carrier_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> crs_o);
endmodule

bind rmii_rx_assembler rmii_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .speed_100 (speed_100),
  .tick      (tick),
  .start_ev  (start_ev),
  .end_ev    (end_ev),
  .byte_vld  (byte_vld),
  .sof_o     (sof_o),
  .eof_o     (eof_o),
  .err_o     (err_o),
  .crs_o     (crs_o)
);

// File: tb/sim_rmii_rx_assembler.sv
`timescale 1ns/1ps
module sim_rmii_rx_assembler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_100 = 1'b1;
  logic [1:0] rxd = 2'b00;
  logic       crs_dv = 1'b0;
  logic       rx_er = 1'b0;
  logic [7:0] byte_o;
  logic       byte_vld, sof_o, eof_o, err_o, crs_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int per = 1;

  logic [7:0] got [0:1023];
  int         got_cyc [0:1023];
  logic [7:0] expb [0:1023];
  int nb, nexp, sof_n, sof_idx, eof_n, eof_cyc;
  logic eof_err;
  logic saw_crs;

  always #5 clk = ~clk;

  rmii_rx_assembler u0 (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .rxd(rxd),
    .crs_dv(crs_dv), .rx_er(rx_er), .byte_o(byte_o), .byte_vld(byte_vld),
    .sof_o(sof_o), .eof_o(eof_o), .err_o(err_o), .crs_o(crs_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) begin
        if (nb < 1024) begin
          got[nb] = byte_o;
          got_cyc[nb] = cyc;
        end
        if (sof_o) begin
          sof_n = sof_n + 1;
          sof_idx = nb;
        end
        nb = nb + 1;
      end
      if (eof_o) begin
        eof_n = eof_n + 1;
        eof_cyc = cyc;
        eof_err = err_o;
      end
      if (crs_o) saw_crs = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] d, input logic dv, input logic er);
    rxd = d;
    crs_dv = dv;
    rx_er = er;
    repeat (per) @(negedge clk);
  endtask

  task automatic clear_mon();
    nb = 0; sof_n = 0; sof_idx = -1; eof_n = 0; eof_cyc = 0;
    eof_err = 1'b0; saw_crs = 1'b0;
  endtask

  // one frame: carrier dibits, preamble, 0xD5, payload, trailing filler, idle
  task automatic run_frame(input bit fast, input int ncar, input int npre, input int npay,
                           input int seed, input int er_at, input int tail, input bit er_out);
    int bidx;
    int p;
    speed_100 = fast;
    per = fast ? 1 : 10;
    repeat (3) put(2'b00, 1'b0, er_out);
    clear_mon();
    nexp = 0;
    for (int i = 0; i < npre; i++) begin expb[nexp] = 8'h55; nexp++; end
    expb[nexp] = 8'hD5; nexp++;
    for (int i = 0; i < npay; i++) begin expb[nexp] = 8'((i * 37 + seed) & 255); nexp++; end
    for (int i = 0; i < ncar; i++) put(2'b00, 1'b1, er_out);
    if (ncar > 0) begin
      // R5 carrier seen before any data
      check(crs_o == 1'b1 && nb == 0, "R5 carrier flag before alignment", crs_o, 1);
    end
    for (int b = 0; b < nexp; b++) begin
      for (int k = 0; k < 4; k++) begin
        bidx = b - npre - 1;
        put(2'((expb[b] >> (2 * k)) & 3), 1'b1, (er_at >= 0 && bidx == er_at && k == 1));
      end
    end
    for (int t = 0; t < tail; t++) put(2'b10, 1'b1, 1'b0);
    repeat (3) put(2'b00, 1'b0, er_out);
    // R2 / R3 byte count and contents
    check(nb == nexp, fast ? "R2 byte count" : "R3 byte count", nb, nexp);
    begin
      int mism;
      int first_bad;
      mism = 0; first_bad = -1;
      for (int i = 0; i < nexp && i < nb; i++)
        if (got[i] !== expb[i]) begin
          mism++;
          if (first_bad < 0) first_bad = i;
        end
      if (first_bad >= 0)
        check(1'b0, fast ? "R2 byte value" : "R3 byte value", got[first_bad], expb[first_bad]);
      else
        check(1'b1, fast ? "R2 byte value" : "R3 byte value", 0, 0);
    end
    // R4 first byte is the aligned preamble
    if (nb > 0) check(got[0] == expb[0], "R4 alignment first byte", got[0], expb[0]);
    // R2 / R3 strobe spacing
    p = fast ? 1 : 10;
    begin
      int badgap;
      badgap = -1;
      for (int i = 1; i < nb && i < 1024; i++)
        if (got_cyc[i] - got_cyc[i-1] != 4 * p && badgap < 0) badgap = got_cyc[i] - got_cyc[i-1];
      check(badgap < 0, fast ? "R2 strobe spacing" : "R3 strobe spacing", badgap, 4 * p);
    end
    // R6 start marker
    check(sof_n == 1 && sof_idx == 0, "R6 sof on first byte only", sof_n * 100 + sof_idx, 100);
    // R7 frame done
    check(eof_n == 1, "R7 eof count", eof_n, 1);
    if (nb > 0)
      check(eof_cyc - got_cyc[nb-1] == p * (1 + tail), "R7 eof distance",
            eof_cyc - got_cyc[nb-1], p * (1 + tail));
    // R8 error flag
    check(eof_err == (er_at >= 0), "R8 error flag", eof_err, er_at >= 0);
    // R5 carrier drops after line low
    check(crs_o == 1'b0, "R5 carrier cleared", crs_o, 0);
  endtask

  task automatic false_carrier(input bit fast, input int ncar);
    speed_100 = fast;
    per = fast ? 1 : 10;
    repeat (3) put(2'b00, 1'b0, 1'b0);
    clear_mon();
    for (int i = 0; i < ncar; i++) put((i % 2) ? 2'b00 : 2'b00, 1'b1, 1'b1);
    repeat (3) put(2'b00, 1'b0, 1'b0);
    // R5 carrier without 01 gives no byte, no eof
    check(saw_crs && nb == 0 && eof_n == 0, "R5 false carrier", nb + eof_n, 0);
    check(crs_o == 1'b0, "R5 carrier cleared after false carrier", crs_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    // R1 reset state
    check({byte_vld, sof_o, eof_o, err_o, crs_o} == 5'b0, "R1 outputs in reset",
          {byte_vld, sof_o, eof_o, err_o, crs_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({byte_vld, sof_o, eof_o, err_o, crs_o} == 5'b0, "R1 outputs after reset",
          {byte_vld, sof_o, eof_o, err_o, crs_o}, 0);

    // R2 all 256 byte values at full speed
    run_frame(1'b1, 2, 7, 256, 0, -1, 0, 1'b0);
    // R7 trailing dibits at both speeds, R4 carrier lengths
    for (int t = 0; t < 4; t++) run_frame(1'b1, t, 7, 12, t * 11, -1, t, 1'b0);
    for (int t = 0; t < 4; t++) run_frame(1'b0, t, 2, 5, t * 53 + 7, -1, t, 1'b0);
    // R3 a wider sweep at 10 Mb/s
    run_frame(1'b0, 1, 7, 48, 101, -1, 0, 1'b0);
    // R8 error frame then clean frame with rx_er toggled outside frames
    run_frame(1'b1, 1, 7, 10, 3, 4, 0, 1'b0);
    run_frame(1'b1, 1, 7, 10, 5, -1, 0, 1'b1);
    run_frame(1'b0, 1, 2, 4, 9, 0, 2, 1'b0);
    run_frame(1'b0, 2, 2, 4, 13, -1, 1, 1'b1);
    // R5 false carriers
    false_carrier(1'b1, 6);
    false_carrier(1'b0, 3);
    // R9 spacing and pulse width are checked on every frame above
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule